// File: doc/BRIEF.md
# Pipelined Minimum-Metric State Finder

This block picks, out of 64 path metrics, the trellis state whose metric is smallest. A Viterbi decoder uses that state as the starting point for traceback. The host pulses a request when the decoder reaches its truncation depth. The block takes the metrics presented in that cycle and passes them through a pipelined compare-and-select tree. Every node of the tree carries a metric together with its 6-bit state number.

The tree has six comparison levels. The first two levels share one register stage and each later level has its own, which gives five register stages in all. A small valid-shift controller moves the search through the stages and refuses new requests while a search is still in flight. When the last stage loads, the winning state number appears on the output together with a one-cycle completion pulse. The number then stays on the output until the next search completes.

Top module: `min_state_finder`

## Requirements
- R1: During and right after a synchronous active-high reset, `done` is 0 and `best_state` is 0.
- R2: After an accepted request, `best_state` equals the index of the smallest metric among the 64 metrics that were presented in the request cycle.
- R3: When several metrics share the smallest value, the lowest index among them is reported.
- R4: If a request is sampled at clock edge e, then `done` is 1 and `best_state` carries the new result in the cycle after edge e+4, which is the fifth cycle after the request cycle.
- R5: `done` is high for exactly one cycle for each accepted request.
- R6: Changes on `path_metrics` after the request cycle have no effect on the result. `best_state` keeps its value until the next completed search.
- R7: A request sampled 1 to 4 edges after an accepted request is ignored. A request in the cycle where `done` is high is accepted, so a request held high continuously is accepted every five cycles.
- R8: Metrics are unsigned 13-bit values, and state i occupies bits [13i+12:13i] of `path_metrics`. The full range from 0 to 8191 compares correctly at both index 0 and index 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| find_req | input | 1 | Search request, sampled at each rising edge |
| path_metrics | input | 832 | 64 packed 13-bit metrics, with state 0 in the lowest bits |
| best_state | output | 6 | Index of the smallest metric from the last completed search |
| done | output | 1 | One-cycle pulse that marks a new result |

## Verification
The bench uses the default geometry of 64 states and 13-bit metrics, so it exercises the real five-stage latency and the combined first stage. Narrow random metric ranges produce frequent ties, which tests lower-index priority at every tree level. Saturated metrics placed at indices 0 and 63 test the edges of the packing. Requests held high continuously, and requests inserted in the middle of a search, test the point where a new search may start and the point where requests are refused.

// File: rtl/minf_pkg.sv
package minf_pkg;

    localparam int STATES   = 64;
    localparam int METRIC_W = 13;
    localparam int IDX_W    = $clog2(STATES);
    localparam int LEVELS   = IDX_W;
    // first two comparison levels share one register stage
    localparam int STAGES   = LEVELS - 1;

    typedef struct packed {
        logic [METRIC_W-1:0] metric;
        logic [IDX_W-1:0]    idx;
    } cand_t;

    // lo always carries the lower index, so it wins ties
    function automatic cand_t keep_smaller(cand_t lo, cand_t hi);
        return (hi.metric < lo.metric) ? hi : lo;
    endfunction

endpackage

// File: rtl/minf_level.sv
module minf_level
    import minf_pkg::*;
#(
    parameter int OUT_CNT = 1
) (
    input  cand_t [2*OUT_CNT-1:0] pairs,
    output cand_t [OUT_CNT-1:0]   winners
);

    for (genvar i = 0; i < OUT_CNT; i++) begin : g_node
        assign winners[i] = keep_smaller(pairs[2*i], pairs[2*i+1]);
    end

endmodule

// File: rtl/minf_ctrl.sv
module minf_ctrl #(
    parameter int NSTG = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    output logic [NSTG-1:0] load,
    output logic            done
);

    logic [NSTG-1:0] live;
    logic            busy;
    logic            accept;

    // final stage holding data does not block a new search
    assign busy   = |live[NSTG-2:0];
    assign accept = req & ~busy;
    assign load   = {live[NSTG-2:0], accept};
    assign done   = live[NSTG-1];

    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else     live <= {live[NSTG-2:0], accept};
    end

endmodule

// File: rtl/minf_tree.sv
module minf_tree
    import minf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [STATES*METRIC_W-1:0]   metrics,
    input  logic [STAGES-1:0]            load,
    output cand_t                        winner
);

    cand_t [STATES-1:0] leaves;

    for (genvar i = 0; i < STATES; i++) begin : g_leaf
        assign leaves[i] = {metrics[i*METRIC_W +: METRIC_W], IDX_W'(i)};
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int N_OUT = STATES >> (l + 1);
        cand_t [2*N_OUT-1:0] src;
        cand_t [N_OUT-1:0]   cmb;
        cand_t [N_OUT-1:0]   res;

        if (l == 0) begin : g_src0
            assign src = leaves;
        end else begin : g_srcn
            assign src = g_lvl[l-1].res;
        end

        minf_level #(.OUT_CNT(N_OUT)) u_lvl (
            .pairs   (src),
            .winners (cmb)
        );

        if (l == 0) begin : g_comb
            assign res = cmb;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)              res <= '0;
                else if (load[l-1])   res <= cmb;
            end
        end
    end

    assign winner = g_lvl[LEVELS-1].res[0];

endmodule

// File: rtl/min_state_finder.sv
module min_state_finder
    import minf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       find_req,
    input  logic [STATES*METRIC_W-1:0] path_metrics,
    output logic [IDX_W-1:0]           best_state,
    output logic                       done
);

    logic [STAGES-1:0] stage_load;
    cand_t             final_cand;

    minf_ctrl #(.NSTG(STAGES)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .req  (find_req),
        .load (stage_load),
        .done (done)
    );

    minf_tree u_tree (
        .clk     (clk),
        .rst     (rst),
        .metrics (path_metrics),
        .load    (stage_load),
        .winner  (final_cand)
    );

    assign best_state = final_cand.idx;

endmodule

// File: rtl/min_state_finder_chk.sv
module min_state_finder_chk
    import minf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             find_req,
    input logic [IDX_W-1:0] best_state,
    input logic             done
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R5

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(find_req, 5));  // R4

    AST_DONE_SPACING: assert property (@(posedge clk) disable iff (rst)
        done |-> !($past(done, 1) || $past(done, 2) || $past(done, 3) || $past(done, 4)));  // R7

    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(best_state));  // R6

endmodule

bind min_state_finder min_state_finder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .find_req   (find_req),
    .best_state (best_state),
    .done       (done)
);

// File: tb/min_state_finder_tb.sv
module min_state_finder_tb;
    import minf_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       find_req = 1'b0;
    logic [STATES*METRIC_W-1:0] path_metrics;
    logic [IDX_W-1:0]           best_state;
    logic                       done;

    logic [METRIC_W-1:0] m [STATES];

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    always_comb begin
        for (int i = 0; i < STATES; i++)
            path_metrics[i*METRIC_W +: METRIC_W] = m[i];
    end

    min_state_finder u_dut (
        .clk          (clk),
        .rst          (rst),
        .find_req     (find_req),
        .path_metrics (path_metrics),
        .best_state   (best_state),
        .done         (done)
    );

    function automatic int ref_min();
        int b = 0;
        for (int i = 1; i < STATES; i++)
            if (m[i] < m[b]) b = i;
        return b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int edge_n, last_acc, pend, exp_state;
    bit exp_done;
    always @(posedge clk) begin
        if (rst) begin
            edge_n = 0; last_acc = -100; exp_done = 0; exp_state = 0; pend = 0;
        end else begin
            edge_n++;
            if (edge_n == last_acc + 4) begin
                exp_done = 1; exp_state = pend;
            end else begin
                exp_done = 0;
            end
            if (find_req && (edge_n - last_acc >= 5)) begin
                pend = ref_min();
                last_acc = edge_n;
            end
        end
    end

    // per-cycle comparison against the model
    bit prev_done = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 done vs model", int'(done), int'(exp_done));
            chk("R2 best_state vs model", int'(best_state), exp_state);
            if (prev_done) chk("R5 done one cycle", int'(done), 0);
            prev_done = done;
        end
    end

    task automatic fill_rand(input int range);
        for (int i = 0; i < STATES; i++) m[i] = METRIC_W'($urandom_range(range));
    endtask

    task automatic fill_const(input int v);
        for (int i = 0; i < STATES; i++) m[i] = METRIC_W'(v);
    endtask

    // one-cycle request, then check the result five cycles later
    task automatic search(input string tag, input int exp);
        find_req = 1'b1;
        @(negedge clk);
        find_req = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " done early"}, int'(done), 0);
        @(negedge clk);
        chk({tag, " done"}, int'(done), 1);
        chk(tag, int'(best_state), exp);
        @(negedge clk);
    endtask

    initial begin
        fill_const(0);
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 state in reset", int'(best_state), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 state after reset", int'(best_state), 0);

        // R2 random searches, wide and narrow ranges
        for (int k = 0; k < 12; k++) begin
            fill_rand((k % 2) ? 8191 : 15);
            search("R2 random search", ref_min());
        end

        // R3 ties
        fill_const(1000);
        search("R3 all equal", 0);
        fill_const(100); m[40] = 5; m[17] = 5;
        search("R3 tie 17/40", 17);
        fill_const(9); m[63] = 3; m[62] = 3;
        search("R3 tie 62/63", 62);

        // R8 extremes and packing
        fill_const(8191); m[63] = 0;
        search("R8 min at 63", 63);
        fill_const(8191); m[0] = 8190;
        search("R8 min at 0", 0);
        fill_const(8191);
        search("R8 all saturated", 0);
        fill_const(1); m[32] = 0;
        search("R8 min at 32", 32);

        // R6 metrics changed after the request cycle
        fill_const(500); m[21] = 7;
        find_req = 1'b1;
        @(negedge clk);
        find_req = 1'b0;
        fill_const(500); m[50] = 1;
        repeat (4) @(negedge clk);
        chk("R6 sampled metrics", int'(best_state), 21);
        repeat (10) @(negedge clk);
        chk("R6 state holds", int'(best_state), 21);
        chk("R6 no done", int'(done), 0);

        // R7 request during a search is ignored
        fill_const(300); m[9] = 2;
        find_req = 1'b1;
        @(negedge clk);
        find_req = 1'b0;
        @(negedge clk);
        fill_const(300); m[44] = 0;
        find_req = 1'b1;
        @(negedge clk);
        find_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 first result", int'(best_state), 9);
        begin
            int extra = 0;
            repeat (8) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R7 busy request ignored", extra, 0);
            chk("R7 result unchanged", int'(best_state), 9);
        end

        // R7 request held high: accepted every five cycles
        begin
            int dones = 0;
            find_req = 1'b1;
            for (int c = 0; c < 16; c++) begin
                fill_rand(63);
                @(negedge clk);
                if (done) dones++;
            end
            find_req = 1'b0;
            repeat (8) begin
                @(negedge clk);
                if (done) dones++;
            end
            chk("R7 held request count", dones, 4);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule